// File: doc/BRIEF.md
# Energy-Detection Spectrum Occupancy Estimator

This block decides whether a band holds a transmission, judging by received energy alone, and estimates where in the band the carrier sits. It needs no knowledge of the signal. An upstream transform delivers per-bin power values one bin per accepted cycle, in ascending bin order. A full observation is `NF` consecutive frames of `N` bins each. The block sums every bin over the observation and scales the sum down to an average. It then slides a `WIN`-tap window across the averaged spectrum and compares each window sum with a threshold. Bins that exceed the threshold mark the occupied region, and the carrier bin is reported as the midpoint between the lowest and the highest such bin.

A controller pulses `start` with the decision threshold on `threshold`, then streams the frames. The block moves through four named states. IDLE goes to ACCUM on `start`. ACCUM goes to SCAN when the final bin of the final frame is accepted. SCAN goes to REPORT after it has visited every window centre. REPORT goes back to IDLE unconditionally and, on that move, updates the results and raises `done` for one cycle. The window is a plain sum of `WIN` averaged bins and is not divided by `WIN`, so the threshold is given on that same scale.

Top module: `ed_occupancy_est`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `detect` and `centre` are all 0.
- R2: A `start` pulse in IDLE captures `threshold` and opens an observation of NF frames of N bins. Only cycles with `bin_valid` high are consumed, taken as bins 0,1,…,N-1 of frame 0, then frame 1, and so on. Changes on `threshold` after the capture have no effect on that evaluation.
- R3: The averaged value of bin k is the sum of its NF frame values shifted right by log2(NF), which truncates the result.
- R4: The smoothed value of bin k is the sum of the averaged values of bins k-2 to k+2 (WIN=5). Indices below 0 or above N-1 contribute zero.
- R5: A bin counts as occupied only if its smoothed value is strictly greater than the captured threshold. Equality does not count.
- R6: When at least one bin is occupied, `detect` is 1 and `centre` equals (lowest occupied bin + highest occupied bin) / 2, with the division truncated.
- R7: When no bin is occupied, `detect` is 0 and `centre` is 0.
- R8: Each evaluation ends with `done` high for exactly one cycle, in the same cycle that `detect` and `centre` take their new values. Between two such pulses, `detect` and `centre` do not change.
- R9: A `start` pulse received while an observation or scan is in progress is ignored, and so is `bin_valid` received in IDLE. Neither of them changes the result of this evaluation or of the next one.
- R10: Occupied bins need not be contiguous. Only the lowest and the highest occupied bin determine `centre`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an observation; sampled in IDLE only |
| threshold | input | PW+3 | Decision threshold on the window-sum scale |
| bin_valid | input | 1 | A bin power value is present this cycle |
| bin_power | input | PW | Power of the current bin |
| done | output | 1 | One-cycle strobe at the end of each evaluation |
| detect | output | 1 | At least one bin exceeded the threshold |
| centre | output | log2(N) | Estimated carrier bin index |

## Verification
The bench places tones at bin 0 and at bin N-1. A design that failed to treat out-of-range window taps as zero would report the wrong centre there, or pick up stale data from a neighbour. A bin sum that loses its fraction only through the truncating shift, and a threshold set exactly equal to a window sum, both expose rounding and off-by-one comparison errors. Two tones far apart expose a design that reports the peak bin instead of the midpoint. Three further cases catch a block that samples the threshold late, restarts on a stray `start`, or accumulates idle `bin_valid` beats: a threshold change mid-observation, a `start` during the scan, and valid beats while idle.

// File: rtl/ed_pkg.sv
package ed_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCUM,
        ST_SCAN,
        ST_REPORT
    } ed_state_e;
endpackage

// File: rtl/ed_accum_mem.sv
module ed_accum_mem #(
    parameter int N  = 64,
    parameter int NF = 8,
    parameter int PW = 16
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic                  wr_first,
    input  logic [$clog2(N)-1:0]  wr_idx,
    input  logic [PW-1:0]         wr_data,
    input  logic [$clog2(N)-1:0]  rd_idx,
    output logic [PW-1:0]         rd_avg
);
    localparam int LOG2NF = $clog2(NF);
    localparam int ACCW   = PW + LOG2NF;

    logic [ACCW-1:0] acc [N];
    logic [ACCW-1:0] base;

    // The first frame overwrites the entry, so no clearing pass is needed.
    assign base = wr_first ? '0 : acc[wr_idx];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            acc[wr_idx] <= base + ACCW'(wr_data);
        end
    end

    assign rd_avg = PW'(acc[rd_idx] >> LOG2NF);
endmodule

// File: rtl/ed_window.sv
module ed_window #(
    parameter int PW  = 16,
    parameter int WIN = 5
) (
    input  logic                        clk,
    input  logic                        clr,
    input  logic                        shift_en,
    input  logic [PW-1:0]               din,
    output logic [PW+$clog2(WIN)-1:0]   sum
);
    localparam int SW = PW + $clog2(WIN);

    logic [PW-1:0] taps [WIN-1];

    generate
        for (genvar i = 0; i < WIN - 1; i++) begin : g_tap
            always_ff @(posedge clk) begin
                if (clr) begin
                    taps[i] <= '0;
                end else if (shift_en) begin
                    if (i == 0) begin
                        taps[i] <= din;
                    end else begin
                        taps[i] <= taps[(i == 0) ? 0 : i - 1];
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        sum = SW'(din);
        for (int j = 0; j < WIN - 1; j++) begin
            sum = sum + SW'(taps[j]);
        end
    end
endmodule

// File: rtl/ed_span_track.sv
module ed_span_track #(
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          hit_valid,
    input  logic          hit,
    input  logic [IW-1:0] idx,
    output logic          found,
    output logic [IW-1:0] lo,
    output logic [IW-1:0] hi
);
    always_ff @(posedge clk) begin
        if (clr) begin
            found <= 1'b0;
            lo    <= '0;
            hi    <= '0;
        end else if (hit_valid && hit) begin
            if (!found) begin
                lo <= idx;
            end
            hi    <= idx;
            found <= 1'b1;
        end
    end
endmodule

// File: rtl/ed_occupancy_est.sv
module ed_occupancy_est
    import ed_pkg::*;
#(
    parameter int N   = 64,
    parameter int NF  = 8,
    parameter int PW  = 16,
    parameter int WIN = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [PW+$clog2(WIN)-1:0]  threshold,
    input  logic                       bin_valid,
    input  logic [PW-1:0]              bin_power,
    output logic                       done,
    output logic                       detect,
    output logic [$clog2(N)-1:0]       centre
);
    localparam int IW        = $clog2(N);
    localparam int SW        = PW + $clog2(WIN);
    localparam int FW        = ($clog2(NF) > 0) ? $clog2(NF) : 1;
    localparam int HALF      = (WIN - 1) / 2;
    localparam int SCAN_LAST = N - 1 + HALF;

    ed_state_e state, state_nx;

    logic [IW-1:0] bin_idx;
    logic [FW-1:0] frame_cnt;
    logic [IW:0]   scan_cnt;
    logic [SW-1:0] thr_q;

    logic          last_bin;
    logic          wr_en;
    logic [PW-1:0] rd_avg;
    logic [PW-1:0] win_in;
    logic [SW-1:0] win_sum;
    logic          hit_valid;
    logic [IW-1:0] cen_idx;
    logic          found;
    logic [IW-1:0] lo_idx, hi_idx;
    logic [IW:0]   mid_sum;

    assign last_bin = (bin_idx == IW'(N - 1)) && (frame_cnt == FW'(NF - 1));
    assign wr_en    = (state == ST_ACCUM) && bin_valid;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start)                       state_nx = ST_ACCUM;
            ST_ACCUM:  if (bin_valid && last_bin)       state_nx = ST_SCAN;
            ST_SCAN:   if (scan_cnt == (IW+1)'(SCAN_LAST)) state_nx = ST_REPORT;
            ST_REPORT:                                  state_nx = ST_IDLE;
            default:                                    state_nx = ST_IDLE;
        endcase
    end

    // Counters, captured threshold and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin_idx   <= '0;
            frame_cnt <= '0;
            scan_cnt  <= '0;
            thr_q     <= '0;
            done      <= 1'b0;
            detect    <= 1'b0;
            centre    <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        thr_q     <= threshold;
                        bin_idx   <= '0;
                        frame_cnt <= '0;
                    end
                end
                ST_ACCUM: begin
                    if (bin_valid) begin
                        bin_idx <= bin_idx + 1'b1;
                        if (bin_idx == IW'(N - 1)) begin
                            frame_cnt <= frame_cnt + 1'b1;
                        end
                        scan_cnt <= '0;
                    end
                end
                ST_SCAN: begin
                    scan_cnt <= scan_cnt + 1'b1;
                end
                ST_REPORT: begin
                    done   <= 1'b1;
                    detect <= found;
                    centre <= found ? IW'(mid_sum >> 1) : '0;
                end
                default: ;
            endcase
        end
    end

    ed_accum_mem #(.N(N), .NF(NF), .PW(PW)) mem_i (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_first (frame_cnt == '0),
        .wr_idx   (bin_idx),
        .wr_data  (bin_power),
        .rd_idx   (scan_cnt[IW-1:0]),
        .rd_avg   (rd_avg)
    );

    // Taps past the top edge read as zero
    assign win_in = (scan_cnt < (IW+1)'(N)) ? rd_avg : '0;

    ed_window #(.PW(PW), .WIN(WIN)) win_i (
        .clk      (clk),
        .clr      (state != ST_SCAN),
        .shift_en (state == ST_SCAN),
        .din      (win_in),
        .sum      (win_sum)
    );

    assign hit_valid = (state == ST_SCAN) && (scan_cnt >= (IW+1)'(HALF));
    assign cen_idx   = scan_cnt[IW-1:0] - IW'(HALF);

    ed_span_track #(.IW(IW)) span_i (
        .clk       (clk),
        .clr       ((state == ST_IDLE) && start),
        .hit_valid (hit_valid),
        .hit       (win_sum > thr_q),
        .idx       (cen_idx),
        .found     (found),
        .lo        (lo_idx),
        .hi        (hi_idx)
    );

    assign mid_sum = {1'b0, lo_idx} + {1'b0, hi_idx};
endmodule

// File: rtl/ed_occupancy_chk.sv
module ed_occupancy_chk
    import ed_pkg::*;
#(
    parameter int IW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input ed_state_e     state,
    input logic          done,
    input logic          detect,
    input logic [IW-1:0] centre
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R8

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(detect) && $stable(centre)));  // R8

    AST_EMPTY_CENTRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !detect) |-> (centre == '0));  // R7

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && start) |=> (state != ST_ACCUM));  // R9

    AST_IDLE_VALID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> (state == ST_IDLE));  // R9
endmodule

bind ed_occupancy_est ed_occupancy_chk #(.IW($clog2(N))) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .state  (state),
    .done   (done),
    .detect (detect),
    .centre (centre)
);

// File: tb/ed_occupancy_est_tb.sv
module ed_occupancy_est_tb_top;
    localparam int N  = 64;
    localparam int NF = 8;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [18:0]   threshold = '0;
    logic          bin_valid = 1'b0;
    logic [PW-1:0] bin_power = '0;
    logic          done;
    logic          detect;
    logic [5:0]    centre;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int pw [NF][N];

    always #5 clk = ~clk;

    ed_occupancy_est #(.N(N), .NF(NF), .PW(PW), .WIN(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .threshold(threshold),
        .bin_valid(bin_valid), .bin_power(bin_power),
        .done(done), .detect(detect), .centre(centre)
    );

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected below 150000", cycles);
            finish_run();
        end
    end

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R3 R4 R5 R6 R7 R10 reference
    function automatic void model(input int thr, output int det, output int cen);
        int avg [N];
        int lo, hi;
        lo = -1; hi = -1;
        for (int k = 0; k < N; k++) begin
            int s = 0;
            for (int f = 0; f < NF; f++) s += pw[f][k];
            avg[k] = s >> 3;
        end
        for (int k = 0; k < N; k++) begin
            int sm = 0;
            for (int j = k - 2; j <= k + 2; j++)
                if (j >= 0 && j < N) sm += avg[j];
            if (sm > thr) begin
                if (lo < 0) lo = k;
                hi = k;
            end
        end
        det = (lo >= 0) ? 1 : 0;
        cen = (lo >= 0) ? (lo + hi) / 2 : 0;
    endfunction

    task automatic clear_pw();
        for (int f = 0; f < NF; f++)
            for (int k = 0; k < N; k++) pw[f][k] = 0;
    endtask

    // mode: 0 plain, 1 gaps, 2 threshold change mid-run, 3 start during scan
    task automatic run_obs(int thr, int mode, string req);
        int det, cen, wait_cnt;
        model(thr, det, cen);
        @(negedge clk);
        threshold = 19'(thr);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int f = 0; f < NF; f++) begin
            for (int k = 0; k < N; k++) begin
                if (mode == 1 && ($urandom % 4 == 0)) begin
                    bin_valid = 1'b0;
                    bin_power = 16'hFFFF;
                    @(negedge clk);
                end
                bin_valid = 1'b1;
                bin_power = 16'(pw[f][k]);
                if (mode == 2 && f == 1) threshold = '0;
                @(negedge clk);
            end
        end
        bin_valid = 1'b0;
        bin_power = '0;
        if (mode == 3) begin
            @(negedge clk);
            start = 1'b1;
            threshold = '0;
            @(negedge clk);
            start = 1'b0;
        end
        wait_cnt = 0;
        while (!done && wait_cnt < 200) begin
            @(negedge clk);
            wait_cnt++;
        end
        check({req, " done seen"}, int'(done), 1);
        check({req, " detect"}, int'(detect), det);
        check({req, " centre"}, int'(centre), cen);
        @(negedge clk);
        check("R8 done one cycle", int'(done), 0);
    endtask

    initial begin
        int det0, cen0, tpos, amp;
        void'($urandom(24681));
        repeat (3) @(negedge clk);
        check("R1 reset done", int'(done), 0);
        check("R1 reset detect", int'(detect), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset centre", int'(centre), 0);
        check("R1 after reset done", int'(done), 0);

        // R7 noise only
        clear_pw();
        for (int f = 0; f < NF; f++) for (int k = 0; k < N; k++) pw[f][k] = $urandom % 50;
        run_obs(1000, 0, "R7 noise only");

        // R6 centred tone
        clear_pw();
        for (int f = 0; f < NF; f++) pw[f][30] = 4000;
        run_obs(1000, 1, "R6 tone at 30");

        // R4 edges
        clear_pw();
        for (int f = 0; f < NF; f++) pw[f][0] = 4000;
        run_obs(1000, 0, "R4 tone at bin 0");
        clear_pw();
        for (int f = 0; f < NF; f++) pw[f][N-1] = 4000;
        run_obs(1000, 0, "R4 tone at last bin");

        // R10 separated tones
        clear_pw();
        for (int f = 0; f < NF; f++) begin pw[f][5] = 3000; pw[f][50] = 3000; end
        run_obs(1000, 0, "R10 two tones");

        // R5 equality boundary: avg 200 at bin 20, window sum 200
        clear_pw();
        for (int f = 0; f < NF; f++) pw[f][20] = 200;
        run_obs(200, 0, "R5 equal not above");
        run_obs(199, 0, "R5 one below");

        // R3 truncation: sum 15 -> 1, sum 7 -> 0
        clear_pw();
        pw[0][10] = 15;
        run_obs(0, 0, "R3 sum 15");
        clear_pw();
        pw[3][10] = 7;
        run_obs(0, 0, "R3 sum 7");

        // R2 threshold change after capture
        clear_pw();
        for (int f = 0; f < NF; f++) for (int k = 0; k < N; k++) pw[f][k] = 40;
        run_obs(5000, 2, "R2 threshold frozen");

        // R9 start during scan, then idle beats
        clear_pw();
        for (int f = 0; f < NF; f++) pw[f][44] = 2000;
        run_obs(900, 3, "R9 busy start");
        repeat (3) @(negedge clk);
        check("R8 hold detect", int'(detect), 1);
        check("R8 hold centre", int'(centre), 44);
        for (int i = 0; i < 12; i++) begin
            bin_valid = 1'b1;
            bin_power = 16'hFFFF;
            @(negedge clk);
        end
        bin_valid = 1'b0;
        check("R9 idle beats no done", int'(done), 0);
        clear_pw();
        for (int f = 0; f < NF; f++) pw[f][12] = 2000;
        run_obs(900, 0, "R9 after idle beats");

        // R2 R6 random
        for (int r = 0; r < 20; r++) begin
            clear_pw();
            tpos = $urandom % N;
            amp = (r % 5 == 0) ? 0 : 500 + $urandom % 6000;
            for (int f = 0; f < NF; f++) begin
                for (int k = 0; k < N; k++) pw[f][k] = $urandom % 64;
                pw[f][tpos] += amp;
                if (tpos + 1 < N) pw[f][tpos+1] += amp / 2;
            end
            model(400 + $urandom % 2000, det0, cen0);
            run_obs(400 + $urandom % 2000, r % 2, "R6 random");
        end

        finish_run();
    end
endmodule